// File: doc/BRIEF.md
# Three-Phase Complementary PWM Output Stage with Dead Time

This block turns three per-phase pulse signals into three complementary output pairs for a motor bridge. Each phase has a high-side output and a low-side output. The high side follows the pulse and the low side follows its inverse. A programmable dead time is inserted on every edge, so a turning-on output always waits for its partner to go off first. The pulse signals come from one-shot timers outside the block, and those timers are started by a carrier underflow event. Each pulse is gated by its own start-enable bit.

The outputs are gated by a pair of double-buffered enable masks, one for the high sides and one for the low sides. In triangular mode, new mask values reach the outputs only on the first carrier underflow after both mask buffers have been written. In sawtooth mode they reach the outputs on every underflow. The block also has three further features:
- a polarity bit that makes all six pins active-high or active-low;
- an interrupt request raised once every n underflows;
- a fault input that drives all six outputs inactive at once, without waiting for a clock edge.

Configuration goes through a simple write port with a 2-bit address:
- address 0 is the control byte;
- address 1 is the dead time;
- address 2 is the high-side mask buffer;
- address 3 is the low-side mask buffer.

Top module: `tpp_core`

## Requirements
- R1: After a synchronous reset, all six outputs are inactive and `irq` is 0. The latched masks reset to 0, so the outputs stay inactive until a mask transfer takes place. The dead-time register resets to 1.
- R2: Control bit 0 selects polarity. When it is 0, a pin is 1 when its output is active. When it is 1, a pin is 0 when its output is active.
- R3: A phase's high-side output is active only while its gated pulse is 1, and its low-side output is active only while the gated pulse is 0. The two outputs of a phase are never active in the same cycle.
- R4: Address 1 holds the dead time DT, from 1 to 255 (a value of 0 acts as 1). With the undivided count clock, one output of a pair becomes active exactly DT clock cycles after its partner became inactive.
- R5: A pulse that is high for DT cycles or fewer never makes the high-side output active. The low side returns DT cycles after the pulse ends.
- R6: The dead-time count clock is divided by 2 when control bit 2 is set, and by 2 again when control bit 3 is set. With a division P, the dead time gap lies between (DT-1)*P+1 and DT*P cycles.
- R7: When a phase's start-enable input (`pulse_en`) is 0, that phase's pulse is treated as 0. The high side goes inactive and the low side becomes active after the dead time.
- R8: Mask bit i enables phase i (U=bit 0, V=bit 1, W=bit 2). Address 2 holds the high-side mask and address 3 the low-side mask. An output whose latched mask bit is 0 stays inactive.
- R9: With control bit 1 = 0 (triangular mode), the mask buffers move to the latches only on the first underflow after both buffers have been written. An underflow that follows a write to only one buffer leaves the outputs unchanged.
- R10: With control bit 1 = 1 (sawtooth mode), the mask buffers move to the latches on every underflow.
- R11: Control bits 7:4 hold n. `irq` pulses for one cycle on every n-th underflow, in the cycle after that underflow is sampled. When n is 0, `irq` never pulses. A write to the control byte restarts the underflow count.
- R12: While `flt_off` is 1, all six outputs are inactive, without waiting for a clock edge. After `flt_off` is released, the outputs resume from the clock edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_off | input | 1 | Asynchronous fault input; forces all outputs inactive |
| carrier_uf | input | 1 | Single-cycle carrier underflow pulse |
| pulse_in | input | 3 | One-shot pulse for each phase (U, V, W) |
| pulse_en | input | 3 | Start-enable for each phase; 0 forces that phase's pulse to 0 |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| out_p | output | 3 | High-side pins U, V, W |
| out_n | output | 3 | Low-side pins U, V, W |
| irq | output | 1 | Decimated underflow interrupt pulse |

## Verification
The bench measures the dead-time gap to the exact cycle at a dead time of 1, at a mid value and at a large value. An off-by-one counter would shift the measured gap by one cycle. It sends a pulse shorter than the dead time, which an output stage that lets a partial count through would turn into a glitch on the high side. It also writes only one mask buffer before an underflow in triangular mode, where a design that transfers on a single write would change the outputs too early.

The bench checks the interrupt spacing for n of 3, 1 and 0; a miscounting divider would raise `irq` too often or never. It raises `flt_off` between clock edges, where an output stage with only synchronous clearing would leave the outputs active for part of a cycle. A monitor that runs through the whole test catches any cycle in which both outputs of a phase are active.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int NPH = 3;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_DT    = 2'd1;
  localparam logic [1:0] A_PMASK = 2'd2;
  localparam logic [1:0] A_NMASK = 2'd3;

  typedef struct packed {
    logic [3:0] irq_n;
    logic       div2;
    logic       clk_sel;
    logic       saw;
    logic       act_low;
  } ctrl_t;
endpackage

// File: rtl/tpp_regs.sv
module tpp_regs
  import tpp_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  input  logic            uf,
  output ctrl_t           ctrl,
  output logic            ctrl_wr,
  output logic [DT_W-1:0] dt_eff,
  output logic [NPH-1:0]  pat_p,
  output logic [NPH-1:0]  pat_n
);
  logic [DT_W-1:0] dt_r;
  logic [NPH-1:0]  buf_p, buf_n;
  logic            full_p, full_n;
  logic            xfer;

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign dt_eff  = (dt_r == '0) ? DT_W'(1) : dt_r;
  assign xfer    = uf && (ctrl.saw || (full_p && full_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      dt_r   <= DT_W'(1);
      buf_p  <= '0;
      buf_n  <= '0;
      full_p <= 1'b0;
      full_n <= 1'b0;
      pat_p  <= '0;
      pat_n  <= '0;
    end else begin
      if (xfer) begin
        pat_p  <= buf_p;
        pat_n  <= buf_n;
        full_p <= 1'b0;
        full_n <= 1'b0;
      end
      if (wr) begin
        case (addr)
          A_CTRL:  ctrl <= ctrl_t'(wdata);
          A_DT:    dt_r <= DT_W'(wdata);
          A_PMASK: begin buf_p <= wdata[NPH-1:0]; full_p <= 1'b1; end
          default: begin buf_n <= wdata[NPH-1:0]; full_n <= 1'b1; end
        endcase
      end
    end
  end
endmodule

// File: rtl/tpp_prescale.sv
module tpp_prescale #(
  parameter int PW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic div2,
  output logic tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_comb begin
    case ({sel, div2})
      2'b00:   tick = 1'b1;
      2'b11:   tick = &cnt[1:0];
      default: tick = cnt[0];
    endcase
  end
endmodule

// File: rtl/tpp_deadband.sv
module tpp_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flt,
  input  logic            tick,
  input  logic [DT_W-1:0] dt,
  input  logic            pulse,
  input  logic            en_p,
  input  logic            en_n,
  output logic            act_p,
  output logic            act_n
);
  logic            s_q;
  logic [DT_W-1:0] cnt;
  logic            done;

  assign done = (cnt >= dt);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= 1'b0;
      cnt <= '0;
    end else begin
      s_q <= pulse;
      if (pulse != s_q)            cnt <= '0;
      else if (tick && (cnt < dt)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge flt) begin
    if (flt) begin
      act_p <= 1'b0;
      act_n <= 1'b0;
    end else if (rst) begin
      act_p <= 1'b0;
      act_n <= 1'b0;
    end else begin
      act_p <= s_q & done & en_p;
      act_n <= ~s_q & done & en_n;
    end
  end
endmodule

// File: rtl/tpp_irqdiv.sv
module tpp_irqdiv #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             uf,
  input  logic [IRQ_W-1:0] n,
  output logic             irq
);
  logic [IRQ_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (uf && (n != '0)) begin
        if (cnt == n - 1'b1) begin
          cnt <= '0;
          irq <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tpp_core.sv
module tpp_core
  import tpp_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flt_off,
  input  logic           carrier_uf,
  input  logic [NPH-1:0] pulse_in,
  input  logic [NPH-1:0] pulse_en,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_addr,
  input  logic [7:0]     cfg_wdata,
  output logic [NPH-1:0] out_p,
  output logic [NPH-1:0] out_n,
  output logic           irq
);
  ctrl_t           ctrl;
  logic            ctrl_wr;
  logic [DT_W-1:0] dt_eff;
  logic [NPH-1:0]  pat_p, pat_n;
  logic [NPH-1:0]  act_p, act_n;
  logic            tick;

  tpp_regs #(.DT_W(DT_W)) i_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .uf(carrier_uf), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .dt_eff(dt_eff),
    .pat_p(pat_p), .pat_n(pat_n)
  );

  tpp_prescale #(.PW(2)) i_pre (
    .clk(clk), .rst(rst), .sel(ctrl.clk_sel), .div2(ctrl.div2), .tick(tick)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    tpp_deadband #(.DT_W(DT_W)) i_db (
      .clk(clk), .rst(rst), .flt(flt_off), .tick(tick), .dt(dt_eff),
      .pulse(pulse_in[g] & pulse_en[g]), .en_p(pat_p[g]), .en_n(pat_n[g]),
      .act_p(act_p[g]), .act_n(act_n[g])
    );
  end

  tpp_irqdiv #(.IRQ_W(4)) i_irq (
    .clk(clk), .rst(rst), .clr(ctrl_wr), .uf(carrier_uf), .n(ctrl.irq_n),
    .irq(irq)
  );

  assign out_p = act_p ^ {NPH{ctrl.act_low}};
  assign out_n = act_n ^ {NPH{ctrl.act_low}};
endmodule

// File: rtl/tpp_chk.sv
module tpp_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           flt_off,
  input logic           carrier_uf,
  input logic [NPH-1:0] act_p,
  input logic [NPH-1:0] act_n,
  input logic [NPH-1:0] pat_p,
  input logic [NPH-1:0] pat_n,
  input logic           irq
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (act_p & act_n) == '0);  // R3
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    flt_off |-> (act_p == '0 && act_n == '0));  // R12
  AST_IRQ_AFTER_UF: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(carrier_uf));  // R11
  AST_MASK_ON_UF: assert property (@(posedge clk) disable iff (rst)
    (pat_p != $past(pat_p) || pat_n != $past(pat_n)) |-> $past(carrier_uf));  // R9
  for (genvar g = 0; g < NPH; g++) begin : g_ph
    AST_RISE_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
      $rose(act_p[g]) |-> $past(!act_n[g]));  // R4
  end
endmodule

bind tpp_core tpp_chk #(.NPH(3)) i_chk (
  .clk(clk), .rst(rst), .flt_off(flt_off), .carrier_uf(carrier_uf),
  .act_p(act_p), .act_n(act_n), .pat_p(pat_p), .pat_n(pat_n), .irq(irq)
);

// File: tb/test_tpp_core.sv
`timescale 1ns/1ps
module test_tpp_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flt_off = 1'b0;
  logic       carrier_uf = 1'b0;
  logic [2:0] pulse_in = '0;
  logic [2:0] pulse_en = 3'b111;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] out_p, out_n;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int ovl = 0;
  bit low_pol = 1'b0;

  tpp_core i_tpp_core (
    .clk(clk), .rst(rst), .flt_off(flt_off), .carrier_uf(carrier_uf),
    .pulse_in(pulse_in), .pulse_en(pulse_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_p(out_p),
    .out_n(out_n), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [2:0] ap();
    return out_p ^ {3{low_pol}};
  endfunction
  function automatic logic [2:0] an();
    return out_n ^ {3{low_pol}};
  endfunction

  always @(negedge clk) if (!rst && ((ap() & an()) != 0)) ovl++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic uf();
    @(negedge clk);
    carrier_uf = 1'b1;
    @(negedge clk);
    carrier_uf = 1'b0;
  endtask

  function automatic logic [7:0] mk(bit lowp, bit saw, bit sel, bit dv, int n);
    return {n[3:0], dv, sel, saw, lowp};
  endfunction

  task automatic setup(input int dt, input logic [7:0] ctl);
    low_pol = ctl[0];
    wr(0, ctl); wr(1, 8'(dt)); wr(2, 8'h7); wr(3, 8'h7);
    uf();
    cyc(3);
  endtask

  task automatic t_reset();
    cyc(1);
    chk(out_p == 0 && out_n == 0, "R1 outputs after reset", {out_p, out_n}, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    rst = 1'b0;
    pulse_in = 3'b101;
    cyc(10);
    chk(ap() == 0 && an() == 0, "R1/R8 masks reset to 0", {out_p, out_n}, 0);
    pulse_in = 0;
  endtask

  task automatic measure(input bit rising, output int gap);
    int c = 0, tf = -1, tr = -1;
    pulse_in[0] = rising;
    for (int k = 0; k < 1100; k++) begin
      @(negedge clk);
      c++;
      if (tf < 0 && (rising ? !an()[0] : !ap()[0])) tf = c;
      if (tr < 0 && (rising ? ap()[0] : an()[0])) begin tr = c; break; end
    end
    gap = (tf < 0 || tr < 0) ? -1 : tr - tf;
  endtask

  task automatic t_deadtime(input int dt);
    int g;
    setup(dt, mk(0, 0, 0, 0, 0));
    pulse_in = 0;
    cyc(dt + 4);
    chk(an()[0] && !ap()[0], "R3 low side active for low pulse", {ap()[0], an()[0]}, 1);
    measure(1'b1, g);
    chk(g == dt, "R4 gap on rising pulse", g, dt);
    cyc(4);
    measure(1'b0, g);
    chk(g == dt, "R4 gap on falling pulse", g, dt);
    cyc(dt + 2);
  endtask

  task automatic t_short();
    bit seen = 0;
    setup(20, mk(0, 0, 0, 0, 0));
    cyc(25);
    pulse_in[0] = 1'b1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (ap()[0]) seen = 1; end
    pulse_in[0] = 1'b0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (ap()[0]) seen = 1; end
    chk(!seen, "R5 short pulse keeps high side off", seen, 0);
    chk(an()[0], "R5 low side returns", an()[0], 1);
  endtask

  task automatic t_prescale(input bit sel, input bit dv);
    int g, p, dt;
    dt = 6;
    p = (sel && dv) ? 4 : 2;
    setup(dt, mk(0, 0, sel, dv, 0));
    pulse_in = 0;
    cyc(40);
    measure(1'b1, g);
    chk(g >= (dt - 1) * p + 1 && g <= dt * p, "R6 divided dead time gap", g, dt * p);
    pulse_in = 0;
    cyc(40);
  endtask

  task automatic t_enable();
    setup(3, mk(0, 0, 0, 0, 0));
    pulse_in = 3'b111;
    cyc(8);
    chk(ap() == 3'b111, "R7 high sides active with enable", ap(), 7);
    pulse_en = 3'b101;
    cyc(8);
    chk(!ap()[1] && an()[1], "R7 cleared enable forces pulse 0", {ap()[1], an()[1]}, 1);
    chk(ap()[0] && ap()[2], "R7 other phases unaffected", ap(), 5);
    pulse_en = 3'b111;
    pulse_in = 0;
    cyc(8);
  endtask

  task automatic t_polarity();
    setup(2, mk(1, 0, 0, 0, 0));
    pulse_in = 0;
    cyc(6);
    chk(out_n == 3'b000 && out_p == 3'b111, "R2 active-low pins", {out_p, out_n}, 56);
    setup(2, mk(0, 0, 0, 0, 0));
    cyc(6);
    chk(out_n == 3'b111 && out_p == 3'b000, "R2 active-high pins", {out_p, out_n}, 7);
  endtask

  task automatic t_triangle();
    setup(2, mk(0, 0, 0, 0, 0));
    pulse_in = 3'b001;
    cyc(6);
    wr(2, 8'h0);
    uf(); cyc(3);
    chk(ap()[0], "R9 single buffer write does not transfer", ap()[0], 1);
    wr(3, 8'h7);
    uf(); cyc(3);
    chk(!ap()[0], "R9 transfer after both buffers written", ap()[0], 0);
    chk(an()[1], "R8 low mask still enables V", an()[1], 1);
    wr(2, 8'h7); wr(3, 8'h7);
    uf(); cyc(6);
    chk(ap()[0], "R8 high mask re-enables U", ap()[0], 1);
    pulse_in = 0;
    cyc(6);
  endtask

  task automatic t_saw();
    setup(2, mk(0, 1, 0, 0, 0));
    pulse_in = 0;
    cyc(6);
    wr(3, 8'h5);
    uf(); cyc(3);
    chk(an() == 3'b101, "R10 sawtooth transfers on one write", an(), 5);
    wr(3, 8'h7);
    uf(); cyc(5);
    chk(an() == 3'b111, "R10 sawtooth transfers again", an(), 7);
  endtask

  task automatic t_irq(input int n, input int nuf);
    int cnt = 0, exp;
    bit bad = 0;
    low_pol = 0;
    wr(0, mk(0, 0, 0, 0, n));
    for (int k = 1; k <= nuf; k++) begin
      @(negedge clk); carrier_uf = 1'b1;
      @(negedge clk); carrier_uf = 1'b0;
      if (irq) begin
        cnt++;
        if (n == 0 || k % n != 0) bad = 1;
      end
      repeat (2) begin @(negedge clk); if (irq) bad = 1; end
    end
    exp = (n == 0) ? 0 : nuf / n;
    chk(cnt == exp && !bad, "R11 irq spacing", cnt, exp);
  endtask

  task automatic t_fault();
    setup(3, mk(0, 0, 0, 0, 0));
    pulse_in = 3'b010;
    cyc(8);
    #1 flt_off = 1'b1;
    #0.5;
    chk(ap() == 0 && an() == 0, "R12 fault clears outputs without an edge", {ap(), an()}, 0);
    cyc(5);
    chk(ap() == 0 && an() == 0, "R12 fault holds outputs off", {ap(), an()}, 0);
    flt_off = 1'b0;
    cyc(3);
    chk(ap() == 3'b010 && an() == 3'b101, "R12 outputs resume", {ap(), an()}, 21);
    pulse_in = 0;
    cyc(6);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    t_deadtime(1);
    t_deadtime(7);
    t_deadtime(200);
    t_short();
    t_prescale(1, 0);
    t_prescale(1, 1);
    t_enable();
    t_polarity();
    t_triangle();
    t_saw();
    t_irq(3, 9);
    t_irq(1, 4);
    t_irq(0, 5);
    t_fault();
    chk(ovl == 0, "R3 no overlapping pair over the run", ovl, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule